// File: doc/BRIEF.md
# Polled Priority Interrupt Controller

This block gathers eight interrupt request lines and hands them to a processor one at a time in fixed priority order. Line 0 has the highest priority and line 7 the lowest. Each line can be set to be sensed on a rising edge or on a high level. The controller holds three 8-bit vectors: pending requests, lines in service and a mask. A request raises the interrupt output only when it is unmasked and outranks every line already in service.

The processor can take an interrupt in two ways. In the first, it answers the interrupt output with a one-cycle acknowledge strobe, and the controller returns an 8-bit vector one cycle later. In the second, software writes a poll command and then reads the controller, and that read acts as the acknowledge. Software closes a service with an end-of-interrupt command, which is either non-specific or names a level. When auto-EOI is enabled, service is closed at the acknowledge itself.

The vector output is a one-cycle valid strobe with no ready: the processor must capture it on the cycle it is valid, and the controller never stalls. Register writes take effect on the next clock edge. Read data is returned one cycle after the read strobe, together with a read-valid flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: With trigger bit 0 (edge mode), a line is latched as pending only on a low-to-high change. It drops from pending if the line falls before it is taken. A line that stays high after being taken raises no new request.
- R2: With trigger bit 1 (level mode), the pending bit follows the line level. A line still high after end-of-interrupt is taken again, and dropping the line removes the request.
- R3: A line whose mask bit is 1 takes no part in priority resolution. Clearing the mask bit lets a request that was already latched through.
- R4: `int_o` is high exactly when the lowest-numbered unmasked pending line has a lower number than every line in service, and no poll is armed.
- R5: An `ack_i` strobe gives `vec_valid_o` high on the next cycle, with `vec_data_o` = {base[4:0], level[2:0]}. It sets that level's in-service bit and clears its edge latch.
- R6: An acknowledge that finds no eligible request returns {base, 3'b111} and leaves the in-service vector unchanged.
- R7: Writing 3'b100 in command bits [7:5] (address 0) arms a poll and forces `int_o` low. The next read of address 0 returns 8'h80 | level when a request is eligible, and 8'h00 otherwise. That read takes the request as an acknowledge would and disarms the poll.
- R8: While a poll is armed, the pending vector does not change, so new edges and levels are not recognised until the poll read.
- R9: Command 3'b001 (non-specific end-of-interrupt) clears the lowest-numbered set in-service bit.
- R10: Command 3'b011 (specific end-of-interrupt) clears the in-service bit named by command bits [2:0].
- R11: With config bit 0 (auto-EOI) set, neither an acknowledge nor a poll read leaves an in-service bit set.
- R12: Write addresses: 0 command, 1 mask, 2 trigger select, 3 config (bits [7:3] vector base, bit 0 auto-EOI). Read addresses: 0 pending (or the poll byte when armed), 1 in-service, 2 mask, 3 trigger, 4 config. Read data appears one cycle after `rd_en_i`, with `rd_valid_o` high. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Interrupt request lines, bit 0 highest priority |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| int_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle after acknowledge |
| vec_data_o | output | 8 | Vector: base and level |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 3 | Register read address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Read data |

## Verification
The bench targets four cases.

- **Request that drops before the acknowledge.** A design that returns the stale level here, or sets its in-service bit, would show a wrong vector or a phantom in-service bit.
- **Nested requests.** A lower-priority arrival must stay silent behind a line in service, while a higher one breaks through. An inverted priority compare would raise or hide `int_o` at the wrong time.
- **Line that rises while a poll is armed.** A design without the freeze would report the new line in the poll byte.
- **Level-mode line held high across end-of-interrupt, and auto-EOI.** The held line must be taken again, and auto-EOI must leave no in-service bit behind. Random traffic is then checked against a cycle model.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    OP_EOI_ANY  = 3'b001,
    OP_EOI_LVL  = 3'b011,
    OP_POLL     = 3'b100
  } op_e;

  typedef enum logic [1:0] {
    WA_CMD  = 2'd0,
    WA_MASK = 2'd1,
    WA_TRIG = 2'd2,
    WA_CFG  = 2'd3
  } wr_addr_e;

  typedef enum logic [2:0] {
    RA_PEND = 3'd0,
    RA_SERV = 3'd1,
    RA_MASK = 3'd2,
    RA_TRIG = 3'd3,
    RA_CFG  = 3'd4
  } rd_addr_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] line_i,
  input  logic [N_IRQ-1:0] level_sel_i,
  input  logic             freeze_i,
  input  logic [N_IRQ-1:0] take_i,
  output logic [N_IRQ-1:0] pend_o
);
  logic [N_IRQ-1:0] prev_q;
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] pend_d;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    always_comb begin
      if (freeze_i) begin
        pend_d[g] = pend_q[g] & ~take_i[g];
      end else if (level_sel_i[g]) begin
        pend_d[g] = line_i[g];
      end else begin
        pend_d[g] = line_i[g] & ((pend_q[g] & ~take_i[g]) | ~prev_q[g]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= line_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && take_i == '0) |=> $stable(pend_q));
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic [N_IRQ-1:0] serv_i,
  output logic             elig_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [N_IRQ-1:0] cand;
  logic             cand_any;
  logic [LVL_W-1:0] cand_lvl;
  logic             serv_any;
  logic [LVL_W-1:0] serv_lvl;

  assign cand = pend_i & ~mask_i;

  always_comb begin
    cand_any = 1'b0;
    cand_lvl = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        cand_any = 1'b1;
        cand_lvl = LVL_W'(i);
      end
    end
  end

  always_comb begin
    serv_any = 1'b0;
    serv_lvl = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (serv_i[i]) begin
        serv_any = 1'b1;
        serv_lvl = LVL_W'(i);
      end
    end
  end

  assign elig_o = cand_any && (!serv_any || (cand_lvl < serv_lvl));
  assign lvl_o  = cand_lvl;

  // R4
  elig_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elig_o |-> ((serv_i & ((N_IRQ'(1) << lvl_o) - N_IRQ'(1))) == '0 && !serv_i[lvl_o]));
  // R3
  masked_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elig_o |-> !mask_i[lvl_o]);
endmodule

// File: rtl/service_regs.sv
module service_regs #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned LVL_W = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] grant_i,
  input  logic             auto_eoi_i,
  input  logic             eoi_any_i,
  input  logic             eoi_lvl_i,
  input  logic [LVL_W-1:0] eoi_sel_i,
  output logic [N_IRQ-1:0] serv_o
);
  logic [N_IRQ-1:0] serv_q;
  logic [N_IRQ-1:0] clr_vec;
  logic [N_IRQ-1:0] set_vec;

  always_comb begin
    clr_vec = '0;
    if (eoi_any_i) begin
      clr_vec = serv_q & (~serv_q + N_IRQ'(1));
    end else if (eoi_lvl_i) begin
      clr_vec = N_IRQ'(1) << eoi_sel_i;
    end
  end

  assign set_vec = auto_eoi_i ? '0 : grant_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serv_q <= '0;
    else        serv_q <= (serv_q & ~clr_vec) | set_vec;
  end

  assign serv_o = serv_q;

  // R11
  auto_eoi_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_eoi_i |=> ((serv_q & ~$past(serv_q)) == '0));
  // R9
  eoi_any_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_any_i && serv_q != '0 && grant_i == '0)
      |=> ($countones(serv_q) + 1 == $countones($past(serv_q))));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int unsigned N_IRQ = 8,
  localparam int unsigned LVL_W  = $clog2(N_IRQ),
  localparam int unsigned DW     = prio_irq_pkg::DATA_W,
  localparam int unsigned BASE_W = DW - LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic             vec_valid_o,
  output logic [DW-1:0]    vec_data_o,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o
);
  import prio_irq_pkg::*;

  logic [N_IRQ-1:0] mask_q, trig_q;
  logic [DW-1:0]    cfg_q;
  logic             poll_q;
  logic [N_IRQ-1:0] pend, serv, grant;
  logic             elig;
  logic [LVL_W-1:0] lvl;
  logic             cmd_wr, poll_rd, take;
  op_e              op;
  logic             vec_valid_q, rd_valid_q;
  logic [DW-1:0]    vec_q, rd_q, rd_d;
  logic [BASE_W-1:0] base;

  assign base    = cfg_q[DW-1:LVL_W];
  assign cmd_wr  = wr_en_i && (wr_addr_e'(wr_addr_i) == WA_CMD);
  assign op      = op_e'(wr_data_i[DW-1:DW-3]);
  assign poll_rd = rd_en_i && (rd_addr_e'(rd_addr_i) == RA_PEND) && poll_q;
  assign take    = (ack_i || poll_rd) && elig;

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      grant[i] = take && (lvl == LVL_W'(i));
    end
  end

  irq_capture #(.N_IRQ(N_IRQ)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_i     (irq_i),
    .level_sel_i(trig_q),
    .freeze_i   (poll_q),
    .take_i     (grant),
    .pend_o     (pend)
  );

  prio_resolver #(.N_IRQ(N_IRQ)) u_resolver (
    .clk   (clk),
    .rst_n (rst_n),
    .pend_i(pend),
    .mask_i(mask_q),
    .serv_i(serv),
    .elig_o(elig),
    .lvl_o (lvl)
  );

  service_regs #(.N_IRQ(N_IRQ)) u_service (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_i   (grant),
    .auto_eoi_i(cfg_q[0]),
    .eoi_any_i (cmd_wr && op == OP_EOI_ANY),
    .eoi_lvl_i (cmd_wr && op == OP_EOI_LVL),
    .eoi_sel_i (wr_data_i[LVL_W-1:0]),
    .serv_o    (serv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      trig_q <= '0;
      cfg_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_e'(wr_addr_i))
        WA_MASK: mask_q <= wr_data_i[N_IRQ-1:0];
        WA_TRIG: trig_q <= wr_data_i[N_IRQ-1:0];
        WA_CFG:  cfg_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     poll_q <= 1'b0;
    else if (cmd_wr && op == OP_POLL) poll_q <= 1'b1;
    else if (poll_rd)               poll_q <= 1'b0;
  end

  always_comb begin
    case (rd_addr_e'(rd_addr_i))
      RA_PEND: begin
        if (poll_q) rd_d = {elig, {(DW-1-LVL_W){1'b0}}, (elig ? lvl : {LVL_W{1'b0}})};
        else        rd_d = DW'(pend);
      end
      RA_SERV: rd_d = DW'(serv);
      RA_MASK: rd_d = DW'(mask_q);
      RA_TRIG: rd_d = DW'(trig_q);
      RA_CFG:  rd_d = cfg_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_q       <= '0;
      rd_valid_q  <= 1'b0;
      rd_q        <= '0;
    end else begin
      vec_valid_q <= ack_i;
      if (ack_i) vec_q <= {base, (elig ? lvl : {LVL_W{1'b1}})};
      rd_valid_q <= rd_en_i;
      if (rd_en_i) rd_q <= rd_d;
    end
  end

  assign int_o       = elig && !poll_q;
  assign vec_valid_o = vec_valid_q;
  assign vec_data_o  = vec_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_q;

  // R5
  ack_gives_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);
  // R7
  poll_silences_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && op == OP_POLL) |=> !int_o);
  // R6
  empty_ack_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !elig) |=> (vec_data_o[LVL_W-1:0] == {LVL_W{1'b1}} && $stable(serv)));
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       ack = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic       int_o, vec_valid, rd_valid;
  logic [7:0] vec_data, rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit model_chk = 1'b0;

  // model state
  logic [7:0] m_pend = '0, m_prev = '0, m_serv = '0, m_mask = '0, m_trig = '0, m_cfg = '0;
  logic       m_poll = 1'b0;
  logic       e_vv, e_rv;
  logic [7:0] e_vec, e_rd;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack), .int_o(int_o),
    .vec_valid_o(vec_valid), .vec_data_o(vec_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [3:0] resolve(input logic [7:0] p, input logic [7:0] m, input logic [7:0] s);
    int c = 8, sv = 8;
    for (int i = 7; i >= 0; i--) begin
      if (p[i] && !m[i]) c = i;
      if (s[i]) sv = i;
    end
    if (c < sv) return {1'b1, 3'(c)};
    return {1'b0, (c < 8) ? 3'(c) : 3'd0};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] r = resolve(m_pend, m_mask, m_serv);
    logic       prd = rd_en && rd_addr == 3'd0 && m_poll;
    logic       tk = (ack || prd) && r[3];
    logic [7:0] gr = tk ? (8'd1 << r[2:0]) : 8'd0;
    logic [7:0] clr = '0;
    logic [7:0] np;
    e_vv = ack;
    if (ack) e_vec = {m_cfg[7:3], r[3] ? r[2:0] : 3'd7};
    e_rv = rd_en;
    if (rd_en) begin
      case (rd_addr)
        3'd0: e_rd = m_poll ? (r[3] ? {5'b10000, r[2:0]} : 8'h00) : m_pend;
        3'd1: e_rd = m_serv;
        3'd2: e_rd = m_mask;
        3'd3: e_rd = m_trig;
        3'd4: e_rd = m_cfg;
        default: e_rd = 8'h00;
      endcase
    end
    for (int i = 0; i < 8; i++) begin
      if (m_poll) np[i] = m_pend[i] & ~gr[i];
      else if (m_trig[i]) np[i] = irq[i];
      else np[i] = irq[i] & ((m_pend[i] & ~gr[i]) | ~m_prev[i]);
    end
    if (wr_en && wr_addr == 2'd0) begin
      if (wr_data[7:5] == 3'b001) clr = m_serv & (~m_serv + 8'd1);
      else if (wr_data[7:5] == 3'b011) clr = 8'd1 << wr_data[2:0];
    end
    m_serv = (m_serv & ~clr) | (m_cfg[0] ? 8'd0 : gr);
    m_pend = np;
    m_prev = irq;
    if (wr_en && wr_addr == 2'd0 && wr_data[7:5] == 3'b100) m_poll = 1'b1;
    else if (prd) m_poll = 1'b0;
    if (wr_en && wr_addr == 2'd1) m_mask = wr_data;
    if (wr_en && wr_addr == 2'd2) m_trig = wr_data;
    if (wr_en && wr_addr == 2'd3) m_cfg = wr_data;
  endtask

  task automatic tick();
    logic [3:0] r;
    model_step();
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    if (model_chk) begin
      r = resolve(m_pend, m_mask, m_serv);
      chk("R4 int_o", {7'd0, int_o}, {7'd0, r[3] && !m_poll});
      chk("R5 vec_valid", {7'd0, vec_valid}, {7'd0, e_vv});
      if (e_vv) chk(e_vec[2:0] == 3'd7 ? "R6 vector" : "R5 vector", vec_data, e_vec);
      chk("R12 rd_valid", {7'd0, rd_valid}, {7'd0, e_rv});
      if (e_rv) chk("R7/R12 read data", rd_data, e_rd);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick();
  endtask
  task automatic rd(input logic [2:0] a);
    rd_en = 1'b1; rd_addr = a; tick();
  endtask
  task automatic do_ack();
    ack = 1'b1; tick();
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset int_o", {7'd0, int_o}, 8'd0);
    rd(3'd1); chk("R12 reset in-service", rd_data, 8'h00);
    rd(3'd4); chk("R12 reset config", rd_data, 8'h00);

    // R1 edge mode
    irq = 8'h08; tick();
    chk("R1 edge raises int", {7'd0, int_o}, 8'd1);
    do_ack();
    chk("R5 vector level 3", vec_data, 8'h03);
    rd(3'd1); chk("R5 in-service set", rd_data, 8'h08);
    wr(2'd0, 8'h20); tick(); tick();
    chk("R1 held line no new int", {7'd0, int_o}, 8'd0);
    rd(3'd0); chk("R1 held line not pending", rd_data, 8'h00);
    irq = 8'h00; tick();

    // R3 mask
    wr(2'd1, 8'h04);
    irq = 8'h04; tick();
    chk("R3 masked no int", {7'd0, int_o}, 8'd0);
    wr(2'd1, 8'h00);
    chk("R3 unmask releases", {7'd0, int_o}, 8'd1);
    do_ack(); chk("R3 vector level 2", vec_data, 8'h02);
    wr(2'd0, 8'h20); irq = 8'h00; tick();

    // R4 nesting, R9, R10
    irq = 8'h20; tick(); do_ack();
    chk("R5 vector level 5", vec_data, 8'h05);
    irq = 8'h60; tick();
    chk("R4 lower level blocked", {7'd0, int_o}, 8'd0);
    irq = 8'h62; tick();
    chk("R4 higher level breaks in", {7'd0, int_o}, 8'd1);
    do_ack(); chk("R4 nested vector", vec_data, 8'h01);
    wr(2'd0, 8'h20);
    rd(3'd1); chk("R9 non-specific clears lowest", rd_data, 8'h20);
    wr(2'd0, 8'h65);
    rd(3'd1); chk("R10 specific clears level 5", rd_data, 8'h00);
    chk("R4 waiting level 6 now raised", {7'd0, int_o}, 8'd1);
    do_ack(); wr(2'd0, 8'h66); irq = 8'h00; tick();

    // R6 dropped request
    irq = 8'h10; tick(); irq = 8'h00; tick();
    chk("R1 dropped line not pending", {7'd0, int_o}, 8'd0);
    do_ack(); chk("R6 default vector", vec_data, 8'h07);
    rd(3'd1); chk("R6 in-service unchanged", rd_data, 8'h00);
    wr(2'd3, 8'hA8);
    do_ack(); chk("R6 default vector with base", vec_data, 8'hAF);

    // R2 level mode
    wr(2'd2, 8'h01);
    irq = 8'h01; tick();
    do_ack(); chk("R2 level vector", vec_data, 8'hA8);
    chk("R2 blocked while in service", {7'd0, int_o}, 8'd0);
    wr(2'd0, 8'h20);
    chk("R2 retaken after EOI", {7'd0, int_o}, 8'd1);
    irq = 8'h00; tick();
    chk("R2 drop clears request", {7'd0, int_o}, 8'd0);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);

    // R7 / R8 poll
    irq = 8'h08; tick();
    wr(2'd0, 8'h80);
    chk("R7 poll forces int low", {7'd0, int_o}, 8'd0);
    irq = 8'h0C; tick();
    rd(3'd0); chk("R8 poll byte ignores frozen edge", rd_data, 8'h83);
    chk("R8 lost edge not raised", {7'd0, int_o}, 8'd0);
    rd(3'd1); chk("R7 poll sets in-service", rd_data, 8'h08);
    wr(2'd0, 8'h20);
    wr(2'd0, 8'h80); rd(3'd0);
    chk("R7 empty poll byte", rd_data, 8'h00);
    irq = 8'h00; tick();

    // R11 auto-EOI
    wr(2'd3, 8'h01);
    irq = 8'h10; tick(); do_ack();
    chk("R11 vector", vec_data, 8'h04);
    rd(3'd1); chk("R11 no in-service after ack", rd_data, 8'h00);
    irq = 8'h00; tick(); irq = 8'h40; tick();
    wr(2'd0, 8'h80); rd(3'd0);
    chk("R11 poll byte", rd_data, 8'h86);
    rd(3'd1); chk("R11 no in-service after poll", rd_data, 8'h00);
    irq = 8'h00; wr(2'd3, 8'h00);
    wr(2'd0, 8'h20); wr(2'd0, 8'h20);

    // random phase
    model_chk = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      int sel = int'($urandom_range(0, 19));
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 7) == 0) irq[b] = ~irq[b];
      case (sel)
        0, 1, 2: ack = 1'b1;
        3, 4:    begin rd_en = 1'b1; rd_addr = 3'($urandom_range(0, 5)); end
        5:       begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'($urandom & $urandom & $urandom); end
        6:       begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'($urandom); end
        7:       begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'($urandom); end
        8, 9:    begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h20; end
        10:      begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = {3'b011, 2'b00, 3'($urandom)}; end
        11:      begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h80; end
        12:      begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'($urandom); end
        default: ;
      endcase
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule